// File: doc/BRIEF.md
# Hit Event Memory with Serializer

This block buffers the discriminator picture of a 64-channel self-triggered front end for a whole bunch train and then sends it out on a single serial line. Each channel's discriminators give a 2-bit threshold state. On every hit strobe the block takes a snapshot of all 128 of those bits. It tags the snapshot with a configurable 8-bit chip identifier and with a 24-bit crossing number, and writes the resulting 160-bit record to the next free slot of an internal store of 128 records. Every channel is stored on every hit, including channels that did not fire.

The crossing number comes from an internal counter. A crossing tick advances it, and an acquisition-start pulse sets it back to zero. When the train is over, a readout-start pulse streams the stored records out one bit per accepted transfer, oldest record first. A one-cycle end-of-readout pulse follows the final bit, and at that point the store is emptied for the next train.

The serial output is a valid/ready stream. A bit is transferred only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the current bit and `tx_valid` are held unchanged, so the receiver may stall for any number of cycles without losing data. The hit input is a plain strobe that cannot be stalled: a hit that arrives while the store is full, or while a readout is in progress, is dropped.

Top module: `hit_record_store`

## Requirements
- R1: The crossing counter becomes 0 on the clock edge after `acq_start`, even if `xing_tick` is high in the same cycle. Otherwise it increments by one on each clock edge where `xing_tick` is high.
- R2: A hit strobe that is accepted stores `chip_id`, the crossing counter value present in that cycle (before any increment from a simultaneous tick), and `disc_bits` as the next record.
- R3: All 128 discriminator bits are stored for every hit, whatever their value (all zeros and all ones included).
- R4: The store holds 128 records. Once 128 records are held, `mem_full` is high, and further hit strobes leave the stored contents unchanged.
- R5: Hit strobes that arrive while a readout is in progress are ignored.
- R6: After `rd_start` with at least one record stored, `tx_valid` goes high on the next cycle. Records leave oldest first, 160 bits each, in this order:
  - the 8-bit chip identifier, MSB first;
  - the 24-bit crossing number, MSB first;
  - channel 0 up to channel 63. Channel c sends `disc_bits[2c+1]` and then `disc_bits[2c]`.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` keep their values on the next cycle. The stream advances only on a cycle where both are high.
- R8: `rd_done` is high for exactly one cycle: the cycle after the transfer of the final bit. In that cycle `tx_valid` is low, the store is empty and `mem_full` is low.
- R9: `rd_start` with no records stored raises `rd_done` for one cycle on the next cycle, and `tx_valid` stays low.
- R10: `rd_start` during a readout has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_start | input | 1 | Start of acquisition; clears the crossing counter |
| xing_tick | input | 1 | One pulse per bunch crossing |
| hit_stb | input | 1 | Hit strobe; captures one record |
| disc_bits | input | 128 | 2-bit discriminator state per channel; channel c is at [2c+1:2c] |
| chip_id | input | 8 | Chip identifier placed at the head of each record |
| rd_start | input | 1 | Starts serial readout of the stored records |
| tx_ready | input | 1 | Receiver accepts the current serial bit |
| tx_data | output | 1 | Serial data bit |
| tx_valid | output | 1 | Serial data bit is valid |
| mem_full | output | 1 | The store holds 128 records |
| rd_done | output | 1 | One-cycle end-of-readout pulse |

## Verification
The sharpest coincidence is a hit strobe that lands on a crossing tick. The bench drives both in the same cycle and expects the record to carry the pre-increment crossing number, with the following hit seeing the incremented one. The same scheme is used on `acq_start` coinciding with a tick, where the next record must carry crossing 0. A second overlap is readout against acquisition: a hit strobe and a second `rd_start` are injected in the middle of a back-pressured stream. The bench judges the result by the exact bit count and record contents of what comes out.

// File: rtl/hre_pkg.sv
package hre_pkg;
  typedef enum logic {
    RS_IDLE,
    RS_SEND
  } rd_state_e;
endpackage

// File: rtl/hre_xing_counter.sv
module hre_xing_counter #(
  parameter int XID_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_start,
  input  logic             xing_tick,
  output logic [XID_W-1:0] xid
);
  always_ff @(posedge clk) begin
    if (!rst_n)         xid <= '0;
    else if (acq_start) xid <= '0;
    else if (xing_tick) xid <= xid + XID_W'(1);
  end

  // R1: a restart always wins over a simultaneous tick
  a_r1_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |=> (xid == '0));
  // R1: with neither input, the count holds
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq_start && !xing_tick) |=> $stable(xid));
endmodule

// File: rtl/hre_record_pack.sv
module hre_record_pack #(
  parameter int NUM_CH  = 64,
  parameter int CH_BITS = 2,
  parameter int XID_W   = 24,
  parameter int HDR_W   = 8,
  localparam int DISC_W = NUM_CH * CH_BITS,
  localparam int REC_W  = HDR_W + XID_W + DISC_W
) (
  input  logic [HDR_W-1:0]  chip_id,
  input  logic [XID_W-1:0]  xid,
  input  logic [DISC_W-1:0] disc_bits,
  output logic [REC_W-1:0]  rec
);
  logic [DISC_W-1:0] ordered;

  // channel 0 lands in the most significant slot so it leaves first
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign ordered[(NUM_CH-1-c)*CH_BITS +: CH_BITS] = disc_bits[c*CH_BITS +: CH_BITS];
  end

  assign rec = {chip_id, xid, ordered};
endmodule

// File: rtl/hre_store.sv
module hre_store #(
  parameter int REC_W = 160,
  parameter int DEPTH = 128,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_stb,
  input  logic [REC_W-1:0] rec_in,
  input  logic             reading,
  input  logic             clear,
  input  logic [AW-1:0]    rd_ptr,
  output logic [REC_W-1:0] rec_out,
  output logic [CNT_W-1:0] count,
  output logic             mem_full
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [REC_W-1:0] mem [DEPTH];
  logic             accept;

  assign mem_full = (count == FULL_CNT);
  assign accept   = hit_stb && !reading && !mem_full;
  assign rec_out  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (accept) count <= count + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (accept) mem[count[AW-1:0]] <= rec_in;
  end

  // R4: occupancy never passes capacity
  a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  // R4: a full store does not grow
  a_r4_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_full && !clear) |=> $stable(count));
  // R5: no record is written while the serializer is busy
  a_r5_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && !clear) |=> $stable(count));
endmodule

// File: rtl/hre_serializer.sv
module hre_serializer
  import hre_pkg::*;
#(
  parameter int REC_W = 160,
  parameter int DEPTH = 128,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BW    = $clog2(REC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_start,
  input  logic [CNT_W-1:0] ev_count,
  input  logic [REC_W-1:0] rec,
  input  logic             tx_ready,
  output logic [AW-1:0]    rd_ptr,
  output logic             tx_data,
  output logic             tx_valid,
  output logic             rd_done,
  output logic             reading,
  output logic             clear
);
  localparam logic [BW-1:0] LAST_BIT = BW'(REC_W - 1);

  rd_state_e     state;
  logic [BW-1:0] bit_idx;
  logic          hs;
  logic          last_bit;
  logic          last_ev;

  assign reading  = (state == RS_SEND);
  assign tx_valid = reading;
  assign tx_data  = rec[LAST_BIT - bit_idx];
  assign hs       = tx_valid && tx_ready;
  assign last_bit = (bit_idx == LAST_BIT);
  assign last_ev  = ((CNT_W'(rd_ptr) + CNT_W'(1)) == ev_count);
  assign clear    = hs && last_bit && last_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RS_IDLE;
      rd_ptr  <= '0;
      bit_idx <= '0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      unique case (state)
        RS_IDLE: begin
          if (rd_start) begin
            if (ev_count == '0) begin
              rd_done <= 1'b1;
            end else begin
              state   <= RS_SEND;
              rd_ptr  <= '0;
              bit_idx <= '0;
            end
          end
        end
        RS_SEND: begin
          if (hs) begin
            if (last_bit) begin
              bit_idx <= '0;
              if (last_ev) begin
                state   <= RS_IDLE;
                rd_done <= 1'b1;
              end else begin
                rd_ptr <= rd_ptr + AW'(1);
              end
            end else begin
              bit_idx <= bit_idx + BW'(1);
            end
          end
        end
        default: state <= RS_IDLE;
      endcase
    end
  end

  // R7: a stalled bit stays put
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R8: end-of-readout lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
endmodule

// File: rtl/hit_record_store.sv
module hit_record_store #(
  parameter int NUM_CH  = 64,
  parameter int CH_BITS = 2,
  parameter int XID_W   = 24,
  parameter int HDR_W   = 8,
  parameter int DEPTH   = 128,
  localparam int DISC_W = NUM_CH * CH_BITS,
  localparam int REC_W  = HDR_W + XID_W + DISC_W,
  localparam int AW     = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_start,
  input  logic              xing_tick,
  input  logic              hit_stb,
  input  logic [DISC_W-1:0] disc_bits,
  input  logic [HDR_W-1:0]  chip_id,
  input  logic              rd_start,
  input  logic              tx_ready,
  output logic              tx_data,
  output logic              tx_valid,
  output logic              mem_full,
  output logic              rd_done
);
  logic [XID_W-1:0] xid;
  logic [REC_W-1:0] rec_in;
  logic [REC_W-1:0] rec_out;
  logic [CNT_W-1:0] count;
  logic [AW-1:0]    rd_ptr;
  logic             reading;
  logic             clear;

  hre_xing_counter #(.XID_W(XID_W)) u_xing (
    .clk(clk), .rst_n(rst_n), .acq_start(acq_start),
    .xing_tick(xing_tick), .xid(xid)
  );

  hre_record_pack #(
    .NUM_CH(NUM_CH), .CH_BITS(CH_BITS), .XID_W(XID_W), .HDR_W(HDR_W)
  ) u_pack (
    .chip_id(chip_id), .xid(xid), .disc_bits(disc_bits), .rec(rec_in)
  );

  hre_store #(.REC_W(REC_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .hit_stb(hit_stb), .rec_in(rec_in),
    .reading(reading), .clear(clear), .rd_ptr(rd_ptr),
    .rec_out(rec_out), .count(count), .mem_full(mem_full)
  );

  hre_serializer #(.REC_W(REC_W), .DEPTH(DEPTH)) u_ser (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .ev_count(count),
    .rec(rec_out), .tx_ready(tx_ready), .rd_ptr(rd_ptr),
    .tx_data(tx_data), .tx_valid(tx_valid), .rd_done(rd_done),
    .reading(reading), .clear(clear)
  );

  // R8: end-of-readout finds the stream idle and the store emptied
  a_r8_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (!tx_valid && !mem_full && (count == '0)));
  // R6: a start with records present opens the stream next cycle
  a_r6_stream_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !reading && (count != '0)) |=> tx_valid);
  // R9: a start on an empty store finishes at once
  a_r9_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !reading && (count == '0)) |=> (rd_done && !tx_valid));
endmodule

// File: tb/hit_record_store_tb.sv
`timescale 1ns/1ps
module hit_record_store_tb;
  localparam int NCH = 64, CB = 2, XW = 24, HW = 8, DEPTH = 128;
  localparam int DW = NCH * CB;
  localparam int RW = HW + XW + DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_start = 1'b0, xing_tick = 1'b0, hit_stb = 1'b0;
  logic rd_start = 1'b0, tx_ready = 1'b1;
  logic [DW-1:0] disc_bits = '0;
  logic [HW-1:0] chip_id = '0;
  logic tx_data, tx_valid, mem_full, rd_done;

  int n_chk = 0;
  int n_bad = 0;
  logic [RW-1:0] exp_q [256];
  int exp_n = 0;
  logic [XW-1:0] m_xid = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  hit_record_store u_dut (
    .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .xing_tick(xing_tick),
    .hit_stb(hit_stb), .disc_bits(disc_bits), .chip_id(chip_id),
    .rd_start(rd_start), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_valid(tx_valid), .mem_full(mem_full), .rd_done(rd_done)
  );

  function automatic logic [RW-1:0] mk(logic [HW-1:0] h, logic [XW-1:0] x, logic [DW-1:0] d);
    logic [RW-1:0] r;
    r[RW-1 -: HW]    = h;
    r[RW-HW-1 -: XW] = x;
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < CB; b++)
        r[DW-1 - c*CB - b] = d[c*CB + CB-1-b];
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(int i);
    return {64'(i) * 64'h9E37_79B9_7F4A_7C15, ~64'(i) ^ 64'h0123_4567_89AB_CDEF};
  endfunction

  task automatic check(bit ok, string req, string what, logic [RW-1:0] act, logic [RW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic hit(logic [DW-1:0] d, bit tick);
    @(negedge clk);
    hit_stb = 1'b1; disc_bits = d; xing_tick = tick;
    if (exp_n < DEPTH) begin
      exp_q[exp_n] = mk(chip_id, m_xid, d);
      exp_n++;
    end
    if (tick) m_xid = m_xid + 1'b1;
    @(negedge clk);
    hit_stb = 1'b0; xing_tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xing_tick = 1'b1; m_xid = m_xid + 1'b1;
      @(negedge clk); xing_tick = 1'b0;
    end
  endtask

  task automatic acq(bit tick);
    @(negedge clk); acq_start = 1'b1; xing_tick = tick; m_xid = '0;
    @(negedge clk); acq_start = 1'b0; xing_tick = 1'b0;
  endtask

  // streams everything out and compares record by record
  task automatic readout(bit bp, bit inject);
    logic [RW-1:0] got;
    int bits, ev, cyc;
    bit prev_stall, prev_d, v, d, r;
    got = '0; bits = 0; ev = 0; cyc = 0; prev_stall = 1'b0; prev_d = 1'b0;
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    while (!rd_done && cyc < 60000) begin
      v = tx_valid; d = tx_data;
      if (prev_stall)
        check(v && (d == prev_d), "R7", "stalled bit changed", RW'({v, d}), RW'({1'b1, prev_d}));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = bp ? lfsr[0] : 1'b1;
      tx_ready = r;
      if (inject && cyc == 40) begin
        hit_stb = 1'b1; rd_start = 1'b1; disc_bits = '1;   // R5, R10
      end else begin
        hit_stb = 1'b0; rd_start = 1'b0;
      end
      if (v && r) begin
        got = {got[RW-2:0], d};
        bits++;
        if (bits % RW == 0) begin
          check(got == exp_q[ev], "R6", $sformatf("record %0d", ev), got, exp_q[ev]);
          ev++;
        end
      end
      prev_stall = v && !r; prev_d = d;
      cyc++;
      @(negedge clk);
    end
    hit_stb = 1'b0; rd_start = 1'b0;
    check(bits == exp_n * RW, "R10", "bits sent", RW'(bits), RW'(exp_n * RW));
    check(rd_done && !tx_valid && !mem_full, "R8", "done/valid/full at end",
          RW'({rd_done, tx_valid, mem_full}), RW'(3'b100));
    @(negedge clk);
    check(!rd_done, "R8", "done is single cycle", RW'(rd_done), RW'(0));
    tx_ready = 1'b1;
    exp_n = 0;
  endtask

  task automatic t_reset();
    check(!tx_valid && !mem_full && !rd_done, "R8", "reset outputs",
          RW'({tx_valid, mem_full, rd_done}), RW'(0));
  endtask

  // R1 R2 R3: tick/hit coincidence, zero and one patterns
  task automatic t_basic();
    chip_id = 8'h5A;
    acq(1'b0);
    ticks(5);
    hit(pat(1), 1'b0);
    ticks(3);
    hit(pat(2), 1'b1);
    hit('0, 1'b0);
    hit('1, 1'b0);
    readout(1'b0, 1'b0);
  endtask

  // R7 R5 R10 R9
  task automatic t_backpressure();
    chip_id = 8'hC3;
    ticks(2);
    hit(pat(7), 1'b0);
    hit(pat(8), 1'b1);
    readout(1'b1, 1'b1);
    readout(1'b0, 1'b0);   // R9: empty store
  endtask

  // R4 and R1 restart priority
  task automatic t_full();
    chip_id = 8'h81;
    acq(1'b1);
    for (int i = 0; i < DEPTH + 2; i++) begin
      hit(pat(100 + i), 1'b1);
      if (i == DEPTH - 2)
        check(!mem_full, "R4", "not full at 127", RW'(mem_full), RW'(0));
      if (i == DEPTH - 1)
        check(mem_full, "R4", "full at 128", RW'(mem_full), RW'(1));
    end
    check(mem_full, "R4", "still full after extra hits", RW'(mem_full), RW'(1));
    readout(1'b0, 1'b0);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_backpressure();
    t_full();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule